// File: doc/BRIEF.md
# Multi-Mode Timer Counter Channel

This block is one programmable 16-bit timer channel. It advances only on clock cycles where its counter-clock enable is high. It turns a reload value and a 3-bit operating mode into one of six output waveforms:

- a terminal-count flag;
- a gate-triggered one-shot;
- a periodic rate pulse;
- a square wave;
- a software-started strobe;
- a gate-started strobe.

A gate input can pause counting or restart it, depending on the mode. The channel output is suited to driving an interrupt line. A second output carries the current count value so that a surrounding register block can latch it for reads.

A load strobe carries the new mode and reload value. Loading takes effect at once, and the elapsed count starts again from zero. All state changes happen on clock edges. The two outputs are registered and show the state produced at that same edge.

Top module: `timer_channel`

## Requirements
- R1: While reset is high, and on the cycle after it, the channel is in mode 3 with a reload of 65536: `out` is 1 and `count` reads 0.
- R2: A `load` pulse stores `load_value` as the reload N, with 0 meaning 65536. On the next cycle `count` shows `load_value` and the elapsed count is zero. A load wins over a gate edge and over a tick in the same cycle.
- R3: Mode value 0 (terminal flag) holds `out` low until N ticks have elapsed. From then on `out` stays high until the next load.
- R4: In mode values 0 and 4, ticks taken while `gate` is low do not advance the channel, and no reload happens.
- R5: Mode value 1 (one-shot) drives `out` high while fewer than N ticks have elapsed since the last load or gate rising edge.
- R6: Mode value 2 (rate) pulses `out` high when the elapsed count is a nonzero multiple of N. `count` reads N minus the elapsed count modulo N.
- R7: Mode value 3 (square) drives `out` high for the first (N+1)/2 ticks of every N-tick period and low for the rest. `count` reads N minus twice the elapsed count, modulo N.
- R8: Mode value 4 (software strobe) raises `out` for exactly one tick when the elapsed count equals N. It does this only once per load.
- R9: Mode value 5 (gate strobe) does not count after a load until a rising edge of `gate`. It then strobes `out` once after N ticks.
- R10: Mode values 6 and 7 behave as mode values 2 and 3.
- R11: A rising edge of `gate` zeroes the elapsed count in mode values 1, 2, 3 and 5. It has no restart effect in modes 0 and 4.
- R12: In mode values 0, 1, 4 and 5, `count` reads (N − elapsed ticks) mod 65536. It keeps decrementing past zero.
- R13: A cycle with `tick` low, no load and no restarting gate edge leaves `out` and `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock enable |
| gate | input | 1 | Gate level, edge-detected inside |
| load | input | 1 | Load strobe for mode and reload value |
| load_mode | input | 3 | Operating mode to load |
| load_value | input | 16 | Reload value, 0 meaning 65536 |
| out | output | 1 | Channel output waveform |
| count | output | 16 | Current count value for latching |

## Verification
The hardest situations to reach are the interactions of the gate with counting:

- a restart edge landing in the same cycle as a load;
- a low gate in the middle of a terminal count;
- a gate-started strobe that has been loaded but not yet armed.

The stimulus reaches these by dropping and raising `gate` on chosen negative edges around `load` pulses. The behavioural model in the bench tracks elapsed ticks as a plain integer and works out the output and count from the mode formulas on every clock. Tick spacing is varied between every cycle, every third cycle, and off.

// File: rtl/timer_chan_pkg.sv
package timer_chan_pkg;

  typedef enum logic [2:0] {
    TM_TERMINAL    = 3'd0,
    TM_ONESHOT     = 3'd1,
    TM_RATE        = 3'd2,
    TM_SQUARE      = 3'd3,
    TM_SOFT_STROBE = 3'd4,
    TM_HW_STROBE   = 3'd5
  } tmode_e;

  // R10: codes 6 and 7 alias the periodic modes
  function automatic tmode_e to_mode(input logic [2:0] code);
    case (code)
      3'd0:    return TM_TERMINAL;
      3'd1:    return TM_ONESHOT;
      3'd2:    return TM_RATE;
      3'd4:    return TM_SOFT_STROBE;
      3'd5:    return TM_HW_STROBE;
      3'd6:    return TM_RATE;
      default: return TM_SQUARE;
    endcase
  endfunction

endpackage

// File: rtl/timer_gate_edge.sv
module timer_gate_edge #(
  parameter logic GATE_IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= GATE_IDLE;
    else     prev_q <= gate;
  end

  assign rise = gate & ~prev_q;
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
  import timer_chan_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int N_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate,
  input  logic             rise,
  input  logic             load,
  input  logic [2:0]       load_mode,
  input  logic [CNT_W-1:0] load_value,
  output tmode_e           mode_q,
  output tmode_e           mode_nx,
  output logic [N_W-1:0]   n_nx,
  output logic [N_W-1:0]   el_nx,
  output logic [N_W-1:0]   ph_nx,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             wrap_nx
);
  localparam logic [N_W-1:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [N_W-1:0]   n_q, el_q, ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q, arm_q, arm_n;
  logic             run, restart;

  always_comb begin
    case (mode_q)
      TM_TERMINAL, TM_SOFT_STROBE: run = gate;   // R4
      TM_HW_STROBE:                run = arm_q;  // R9
      default:                     run = 1'b1;
    endcase
    restart = rise && (mode_q inside {TM_ONESHOT, TM_RATE, TM_SQUARE, TM_HW_STROBE});
  end

  always_comb begin
    mode_nx = mode_q;
    n_nx    = n_q;
    el_nx   = el_q;
    ph_nx   = ph_q;
    cnt_nx  = cnt_q;
    wrap_nx = wrap_q;
    arm_n   = arm_q;
    if (load) begin
      mode_nx = to_mode(load_mode);
      n_nx    = (load_value == '0) ? FULL : {1'b0, load_value};
      el_nx   = '0;
      ph_nx   = '0;
      cnt_nx  = load_value;
      wrap_nx = 1'b0;
      arm_n   = (to_mode(load_mode) != TM_HW_STROBE);
    end else if (restart) begin       // R11
      el_nx   = '0;
      ph_nx   = '0;
      cnt_nx  = n_q[CNT_W-1:0];
      wrap_nx = 1'b0;
      arm_n   = 1'b1;
    end else if (tick && run) begin
      if (el_q <= n_q) el_nx = el_q + 1'b1;  // saturate at N+1
      cnt_nx = cnt_q - 1'b1;
      if (ph_q + 1'b1 == n_q) begin
        ph_nx   = '0;
        wrap_nx = 1'b1;
      end else begin
        ph_nx = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TM_SQUARE;
      n_q    <= FULL;
      el_q   <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      arm_q  <= 1'b1;
    end else begin
      mode_q <= mode_nx;
      n_q    <= n_nx;
      el_q   <= el_nx;
      ph_q   <= ph_nx;
      cnt_q  <= cnt_nx;
      wrap_q <= wrap_nx;
      arm_q  <= arm_n;
    end
  end

  assert_phase_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (ph_q < n_q) && (n_q != '0));

  assert_elapsed_cap_R12: assert property (@(posedge clk) disable iff (rst)
    el_q <= n_q + 1'b1);
endmodule

// File: rtl/timer_wave_decode.sv
module timer_wave_decode
  import timer_chan_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int N_W = CNT_W + 1
) (
  input  tmode_e           mode,
  input  logic [N_W-1:0]   n,
  input  logic [N_W-1:0]   el,
  input  logic [N_W-1:0]   ph,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrapped,
  output logic             wave,
  output logic [CNT_W-1:0] count
);
  logic [N_W:0] twice, half;

  always_comb begin
    twice = {ph, 1'b0};
    if (twice >= {1'b0, n}) twice = twice - {1'b0, n};
    half = ({1'b0, n} + 1'b1) >> 1;
    case (mode)
      TM_TERMINAL: begin wave = (el >= n); count = cnt; end
      TM_ONESHOT:  begin wave = (el < n);  count = cnt; end
      TM_RATE: begin
        wave  = wrapped && (ph == '0);
        count = CNT_W'(n - ph);
      end
      TM_SQUARE: begin
        wave  = ({1'b0, ph} < half);
        count = CNT_W'(n - twice[N_W-1:0]);
      end
      default: begin wave = (el == n); count = cnt; end
    endcase
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_chan_pkg::*;
#(
  parameter int   CNT_W     = 16,
  parameter logic GATE_IDLE = 1'b1,
  localparam int  N_W       = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate,
  input  logic             load,
  input  logic [2:0]       load_mode,
  input  logic [CNT_W-1:0] load_value,
  output logic             out,
  output logic [CNT_W-1:0] count
);
  logic             rise, wrap_nx, wave_d;
  tmode_e           mode_q, mode_nx;
  logic [N_W-1:0]   n_nx, el_nx, ph_nx;
  logic [CNT_W-1:0] cnt_nx, count_d, count_q;
  logic             out_q;

  timer_gate_edge #(.GATE_IDLE(GATE_IDLE)) u_edge (
    .clk(clk), .rst(rst), .gate(gate), .rise(rise));

  timer_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .rise(rise),
    .load(load), .load_mode(load_mode), .load_value(load_value),
    .mode_q(mode_q), .mode_nx(mode_nx), .n_nx(n_nx), .el_nx(el_nx),
    .ph_nx(ph_nx), .cnt_nx(cnt_nx), .wrap_nx(wrap_nx));

  timer_wave_decode #(.CNT_W(CNT_W)) u_dec (
    .mode(mode_nx), .n(n_nx), .el(el_nx), .ph(ph_nx), .cnt(cnt_nx),
    .wrapped(wrap_nx), .wave(wave_d), .count(count_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 1'b1;
      count_q <= '0;
    end else begin
      out_q   <= wave_d;
      count_q <= count_d;
    end
  end

  assign out   = out_q;
  assign count = count_q;

  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (out_q && count_q == '0));

  assert_load_count_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (count_q == $past(load_value)));

  assert_terminal_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TM_TERMINAL && out_q && !load) |=> out_q);

  assert_strobe_once_R8: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == TM_SOFT_STROBE || mode_q == TM_HW_STROBE) && out_q && tick
     && !load && !rise && (mode_q == TM_HW_STROBE || gate)) |=> !out_q);

  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load && !rise) |=> ($stable(count_q) && $stable(out_q)));
endmodule

// File: tb/timer_channel_test.sv
`timescale 1ns/1ps
module timer_channel_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic gate = 1'b1;
  logic load = 1'b0;
  logic [2:0] load_mode = 3'd0;
  logic [15:0] load_value = 16'd0;
  logic out;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int gap = 1;
  int tc = 0;

  // reference model state
  longint m_d = 0;
  longint m_n = 65536;
  int     m_mode = 3;
  bit     m_arm = 1;
  bit     m_gprev = 1;
  bit     model_ok = 0;

  timer_channel uut (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .load(load),
    .load_mode(load_mode), .load_value(load_value), .out(out), .count(count));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_out();
    case (m_mode)
      0: return m_d >= m_n;
      1: return m_d < m_n;
      2: return (m_d % m_n == 0) && (m_d != 0);
      3: return (m_d % m_n) < ((m_n + 1) / 2);
      4: return m_d == m_n;
      default: return m_arm && (m_d == m_n);
    endcase
  endfunction

  function automatic longint exp_count();
    case (m_mode)
      2: return (m_n - (m_d % m_n)) & 65535;
      3: return (m_n - ((2 * m_d) % m_n)) & 65535;
      default: return (m_n - m_d) & 65535;
    endcase
  endfunction

  function automatic string out_tag();
    case (m_mode)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic string cnt_tag();
    case (m_mode)
      2: return "R6";
      3: return "R7";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    bit rise, run;
    if (rst) begin
      m_d = 0; m_n = 65536; m_mode = 3; m_arm = 1; m_gprev = 1;
    end else begin
      rise = gate && !m_gprev;
      m_gprev = gate;
      run = (m_mode == 0 || m_mode == 4) ? gate : (m_mode == 5) ? m_arm : 1'b1;
      if (load) begin
        m_n = (load_value == 0) ? 65536 : load_value;
        m_mode = (load_mode > 5) ? load_mode - 4 : load_mode;
        m_d = 0;
        m_arm = (m_mode != 5);
      end else if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
        m_d = 0;
        m_arm = 1;
      end else if (tick && run) begin
        m_d = m_d + 1;
      end
    end
    model_ok = 1;
  end

  always @(negedge clk) begin
    if (model_ok) begin
      chk(out === exp_out(), rst ? "R1" : out_tag(), out, exp_out());
      chk(count === exp_count(), rst ? "R1" : cnt_tag(), count, exp_count());
    end
    tc++;
    tick = (gap != 0) && (tc % gap == 0);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input int m, input int v);
    @(negedge clk);
    load = 1'b1; load_mode = 3'(m); load_value = 16'(v);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    longint c0;
    bit o0;
    run(3);
    chk(out === 1'b1, "R1 out in reset", out, 1);
    chk(count === 16'd0, "R1 count in reset", count, 0);
    rst = 1'b0;
    run(50);
    // square wave, odd and even periods
    do_load(3, 5);  run(25);
    do_load(3, 6);  run(25);
    do_load(3, 1);  run(5);
    // terminal count with gate pause
    do_load(0, 10); run(3);
    gate = 1'b0; @(negedge clk);
    c0 = count;
    run(5);
    chk(count === 16'(c0), "R4 paused count", count, c0);
    gate = 1'b1; run(20);
    gap = 3;
    do_load(0, 4); run(30);
    // one-shot with retrigger
    gap = 1;
    do_load(1, 7); run(12);
    gate = 1'b0; run(2); gate = 1'b1; run(12);
    // rate with retrigger and load priority
    do_load(2, 4); run(6);
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; @(negedge clk);
    chk(count === 16'd4, "R11 restart count", count, 4);
    chk(out === 1'b0, "R11 restart out", out, 0);
    run(10);
    gate = 1'b0; @(negedge clk);
    gate = 1'b1; load = 1'b1; load_mode = 3'd1; load_value = 16'd9;
    @(negedge clk); load = 1'b0;
    chk(count === 16'd9, "R11 load wins", count, 9);
    run(12);
    do_load(2, 1); run(5);
    // software strobe, sparse ticks and gate pause
    gap = 3;
    do_load(4, 5); run(20);
    gate = 1'b0; run(6); gate = 1'b1; run(20);
    gap = 1;
    do_load(4, 3); run(10);
    // hardware strobe
    gate = 1'b0;
    do_load(5, 6); run(10);
    chk(count === 16'd6, "R9 waits for gate", count, 6);
    chk(out === 1'b0, "R9 no strobe before gate", out, 0);
    gate = 1'b1; run(20);
    gate = 1'b0; run(2); gate = 1'b1; run(12);
    // alias modes
    do_load(6, 3);
    chk(count === 16'd3, "R10 mode 6 count", count, 3);
    chk(out === 1'b0, "R10 mode 6 out", out, 0);
    run(3);
    chk(out === 1'b1, "R10 mode 6 pulse", out, 1);
    run(10);
    do_load(7, 5); run(20);
    // zero reload
    do_load(0, 0);
    chk(count === 16'd0, "R2 zero reload count", count, 0);
    chk(out === 1'b0, "R2 zero reload out", out, 0);
    run(5);
    chk(count === 16'd65531, "R2 R12 wrap below zero", count, 65531);
    run(20);
    // tick held low
    do_load(3, 8); run(5);
    gap = 0; run(2);
    c0 = count; o0 = out;
    run(6);
    chk(count === 16'(c0), "R13 count held", count, c0);
    chk(out === o0, "R13 out held", out, o0);
    gap = 1; run(10);
    summary();
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R13 actual=%0d expected=%0d", 0, 1);
    summary();
  end
endmodule